// File: doc/BRIEF.md
# GPIO Register Bank with Shared Stream Buffer

This block is a 32-bit bus slave that sits between the processor system bus and a bit-streaming engine. A small register window holds a control word for the engine, a read-only view of the input pins, an output-pin value and an output-enable mask. A second window gives word access to a 32-word buffer that the streaming engine also reads and writes.

The buffer has one port. While the engine signals that it is busy, the engine owns that port outright. A bus access to the buffer in that period still completes, but it has no effect. Software therefore loads outgoing stream data before it starts the engine, and it collects captured data once the engine reports idle. The engine can clear the capture-enable and emit-enable control bits through strobes when a stream finishes. A clear strobe wins over a bus write that lands in the same cycle.

Every accepted request receives one acknowledge in the next cycle. Read data is valid in that same cycle.

Top module: `gsr_bus_regs`

## Requirements
- R1: After reset, bus_ack, ctrl_word, pin_out and pin_oe are all zero, and the control register reads back as zero.
- R2: A request (bus_cyc and bus_stb high while bus_ack is low) is acknowledged in the following cycle. The acknowledge lasts exactly one cycle.
- R3: Byte offset 0x0 holds the control word, offset 0x8 holds the output value and offset 0xC holds the output-enable mask. Each is readable and writable, and each bus_sel bit gates one byte lane (bit n covers data bits 8n+7..8n).
- R4: Offset 0x4 returns pin_in as it stood after a two-flop synchroniser at the request edge. A change on pin_in shows only from the second clock edge on. Writes to this offset have no effect.
- R5: Offsets 0x80 to 0xFC address the 32-word buffer. Word index = address bits 6..2, and bus_sel is ignored for the buffer.
- R6: While eng_busy is high at the request edge, a buffer write is dropped and a buffer read returns zero. Both are still acknowledged.
- R7: While eng_busy is high, the engine port reads and writes the buffer. Engine read data appears on eng_ram_rdata one cycle after eng_ram_en. Data written by either side is visible to the other.
- R8: Control bit 0 (capture enable) is cleared by clr_capture, and bit 1 (emit enable) is cleared by clr_emit. Each clear takes priority over a bus write in the same cycle.
- R9: Offsets 0x10 to 0x7C read as zero. Writes to them change no register.
- R10: ctrl_word, pin_out and pin_oe continuously present the stored register values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cyc | input | 1 | Bus cycle active |
| bus_stb | input | 1 | Bus strobe |
| bus_we | input | 1 | Write when high |
| bus_adr | input | 8 | Byte offset in the window |
| bus_sel | input | 4 | Byte lane enables |
| bus_dat_w | input | 32 | Write data |
| bus_dat_r | output | 32 | Read data, valid with bus_ack |
| bus_ack | output | 1 | One-cycle acknowledge |
| pin_in | input | 32 | Asynchronous input pins |
| pin_out | output | 32 | Output pin values |
| pin_oe | output | 32 | Output enable per pin |
| ctrl_word | output | 32 | Control word for the streaming engine |
| eng_busy | input | 1 | Engine owns the buffer |
| clr_capture | input | 1 | Clears capture-enable bit 0 |
| clr_emit | input | 1 | Clears emit-enable bit 1 |
| eng_ram_en | input | 1 | Engine buffer access strobe |
| eng_ram_we | input | 1 | Engine write when high |
| eng_ram_addr | input | 5 | Engine word index |
| eng_ram_wdata | input | 32 | Engine write data |
| eng_ram_rdata | output | 32 | Buffer read data for the engine |

## Verification
Register writes are tried with full byte enables and with a sparse lane mask. This separates lane gating from a plain word store. Buffer accesses hit the first word, the last word and one in the middle, so a wrong index slice shows up.

The same buffer word is written and read once with the engine idle and once with it busy. The only difference between the two is ownership, so any leak of a dropped write or a stale read is exposed. The input pins are read immediately after they change and again one access later, which pins down the synchroniser depth. Clear strobes are raised in the exact accept cycle of a bus write, so that the bench sees which of the two wins.

// File: rtl/gsr_pkg.sv
package gsr_pkg;
  typedef enum logic [1:0] {
    REG_CTRL    = 2'd0,
    REG_PIN_IN  = 2'd1,
    REG_PIN_OUT = 2'd2,
    REG_PIN_OE  = 2'd3
  } reg_idx_e;

  localparam int unsigned CAP_BIT  = 0;
  localparam int unsigned EMIT_BIT = 1;
endpackage

// File: rtl/gsr_sync.sv
module gsr_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gsr_ram.sv
module gsr_ram #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      rdata_q <= mem[addr];
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/gsr_regs.sv
module gsr_regs
  import gsr_pkg::*;
#(
  parameter int W     = 32,
  localparam int SEL_W = W / 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  reg_idx_e         wr_idx,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [W-1:0]     wr_data,
  input  logic             clr_cap,
  input  logic             clr_emit,
  output logic [W-1:0]     ctrl_q,
  output logic [W-1:0]     out_q,
  output logic [W-1:0]     oe_q
);
  logic [W-1:0] ctrl_m, out_m, oe_m, clr_mask;

  for (genvar b = 0; b < SEL_W; b++) begin : g_lane
    assign ctrl_m[b*8 +: 8] = (wr_en && wr_idx == REG_CTRL && wr_sel[b])
                              ? wr_data[b*8 +: 8] : ctrl_q[b*8 +: 8];
    assign out_m[b*8 +: 8]  = (wr_en && wr_idx == REG_PIN_OUT && wr_sel[b])
                              ? wr_data[b*8 +: 8] : out_q[b*8 +: 8];
    assign oe_m[b*8 +: 8]   = (wr_en && wr_idx == REG_PIN_OE && wr_sel[b])
                              ? wr_data[b*8 +: 8] : oe_q[b*8 +: 8];
  end

  always_comb begin
    clr_mask           = '0;
    clr_mask[CAP_BIT]  = clr_cap;
    clr_mask[EMIT_BIT] = clr_emit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      out_q  <= '0;
      oe_q   <= '0;
    end else begin
      ctrl_q <= ctrl_m & ~clr_mask;
      out_q  <= out_m;
      oe_q   <= oe_m;
    end
  end

  // R8: a hardware clear beats any same-cycle bus write
  p_cap_clear_wins_r8: assert property (@(posedge clk) disable iff (rst)
    clr_cap |=> !ctrl_q[CAP_BIT]);
  p_emit_clear_wins_r8: assert property (@(posedge clk) disable iff (rst)
    clr_emit |=> !ctrl_q[EMIT_BIT]);
  // R3: the enable mask moves only on a write aimed at it
  p_oe_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_idx == REG_PIN_OE) |=> $stable(oe_q));
endmodule

// File: rtl/gsr_bus_regs.sv
module gsr_bus_regs
  import gsr_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int RAM_WORDS   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                                          clk,
  input  logic                                          rst,
  input  logic                                          bus_cyc,
  input  logic                                          bus_stb,
  input  logic                                          bus_we,
  input  logic [$clog2(DATA_W/8)+$clog2(RAM_WORDS):0]   bus_adr,
  input  logic [DATA_W/8-1:0]                           bus_sel,
  input  logic [DATA_W-1:0]                             bus_dat_w,
  output logic [DATA_W-1:0]                             bus_dat_r,
  output logic                                          bus_ack,
  input  logic [DATA_W-1:0]                             pin_in,
  output logic [DATA_W-1:0]                             pin_out,
  output logic [DATA_W-1:0]                             pin_oe,
  output logic [DATA_W-1:0]                             ctrl_word,
  input  logic                                          eng_busy,
  input  logic                                          clr_capture,
  input  logic                                          clr_emit,
  input  logic                                          eng_ram_en,
  input  logic                                          eng_ram_we,
  input  logic [$clog2(RAM_WORDS)-1:0]                  eng_ram_addr,
  input  logic [DATA_W-1:0]                             eng_ram_wdata,
  output logic [DATA_W-1:0]                             eng_ram_rdata
);
  localparam int BYTE_LSB = $clog2(DATA_W / 8);
  localparam int RAM_AW   = $clog2(RAM_WORDS);
  localparam int RAM_BIT  = BYTE_LSB + RAM_AW;

  logic              ack_q, sel_ram_q, blocked_q;
  logic [DATA_W-1:0] reg_rdata_q, reg_mux, pin_sync;
  logic [DATA_W-1:0] ctrl_q, out_q, oe_q, ram_rdata, ram_wdata;
  logic              req, ram_hit, reg_hit, bus_ram_go, ram_en, ram_we;
  logic [RAM_AW-1:0] ram_addr;
  reg_idx_e          reg_idx;
  logic              unused_adr_lsb;

  assign unused_adr_lsb = ^bus_adr[BYTE_LSB-1:0];

  // request and address decode
  assign req     = bus_cyc && bus_stb && !ack_q;
  assign ram_hit = bus_adr[RAM_BIT];
  assign reg_hit = !bus_adr[RAM_BIT] && (bus_adr[RAM_BIT-1:BYTE_LSB+2] == '0);
  assign reg_idx = reg_idx_e'(bus_adr[BYTE_LSB+1:BYTE_LSB]);

  gsr_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pin_sync)
  );

  gsr_regs #(.W(DATA_W)) i_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (req && bus_we && reg_hit),
    .wr_idx   (reg_idx),
    .wr_sel   (bus_sel),
    .wr_data  (bus_dat_w),
    .clr_cap  (clr_capture),
    .clr_emit (clr_emit),
    .ctrl_q   (ctrl_q),
    .out_q    (out_q),
    .oe_q     (oe_q)
  );

  // buffer port: engine owns it while busy
  assign bus_ram_go = req && ram_hit && !eng_busy;
  assign ram_en     = eng_busy ? eng_ram_en : bus_ram_go;
  assign ram_we     = eng_busy ? (eng_ram_en && eng_ram_we) : (bus_ram_go && bus_we);
  assign ram_addr   = eng_busy ? eng_ram_addr : bus_adr[BYTE_LSB +: RAM_AW];
  assign ram_wdata  = eng_busy ? eng_ram_wdata : bus_dat_w;

  gsr_ram #(.W(DATA_W), .DEPTH(RAM_WORDS)) i_ram (
    .clk   (clk),
    .en    (ram_en),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (ram_rdata)
  );

  always_comb begin
    unique case (reg_idx)
      REG_CTRL:    reg_mux = ctrl_q;
      REG_PIN_IN:  reg_mux = pin_sync;
      REG_PIN_OUT: reg_mux = out_q;
      REG_PIN_OE:  reg_mux = oe_q;
      default:     reg_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q       <= 1'b0;
      sel_ram_q   <= 1'b0;
      blocked_q   <= 1'b0;
      reg_rdata_q <= '0;
    end else begin
      ack_q     <= req;
      sel_ram_q <= req && ram_hit;
      blocked_q <= req && ram_hit && eng_busy;
      if (req) reg_rdata_q <= reg_hit ? reg_mux : '0;
    end
  end

  assign bus_ack       = ack_q;
  assign bus_dat_r     = sel_ram_q ? (blocked_q ? '0 : ram_rdata) : reg_rdata_q;
  assign eng_ram_rdata = ram_rdata;
  assign ctrl_word     = ctrl_q;
  assign pin_out       = out_q;
  assign pin_oe        = oe_q;

  // R2: no acknowledge lasts longer than one cycle
  p_ack_one_cycle_r2: assert property (@(posedge clk) disable iff (rst)
    bus_ack |=> !bus_ack);
  // R6: a buffer read issued while the engine is busy returns zero
  p_busy_read_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (req && !bus_we && ram_hit && eng_busy) |=> (bus_dat_r == '0));
  // R9: a read of a hole in the map returns zero
  p_hole_read_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (req && !bus_we && !ram_hit && !reg_hit) |=> (bus_dat_r == '0));
endmodule

// File: tb/test_gsr_bus_regs.sv
`timescale 1ns/1ps
module test_gsr_bus_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_cyc = 0, bus_stb = 0, bus_we = 0;
  logic [7:0]  bus_adr = '0;
  logic [3:0]  bus_sel = '0;
  logic [31:0] bus_dat_w = '0;
  logic [31:0] bus_dat_r;
  logic        bus_ack;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe, ctrl_word;
  logic        eng_busy = 0, clr_capture = 0, clr_emit = 0;
  logic        eng_ram_en = 0, eng_ram_we = 0;
  logic [4:0]  eng_ram_addr = '0;
  logic [31:0] eng_ram_wdata = '0;
  logic [31:0] eng_ram_rdata;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  bit cur_is_read = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  gsr_bus_regs i_gsr_bus_regs (
    .clk(clk), .rst(rst), .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we),
    .bus_adr(bus_adr), .bus_sel(bus_sel), .bus_dat_w(bus_dat_w), .bus_dat_r(bus_dat_r),
    .bus_ack(bus_ack), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .ctrl_word(ctrl_word), .eng_busy(eng_busy), .clr_capture(clr_capture),
    .clr_emit(clr_emit), .eng_ram_en(eng_ram_en), .eng_ram_we(eng_ram_we),
    .eng_ram_addr(eng_ram_addr), .eng_ram_wdata(eng_ram_wdata),
    .eng_ram_rdata(eng_ram_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data on each read acknowledge
  always @(negedge clk) begin
    if (!rst && bus_ack && cur_is_read) begin
      if (exp_q.size() == 0) check("R2 unexpected read ack", 32'h1, 32'h0);
      else check(tag_q.pop_front(), bus_dat_r, exp_q.pop_front());
    end
  end

  task automatic xfer(input bit we, input logic [7:0] adr, input logic [3:0] sel,
                      input logic [31:0] data, input logic [31:0] exp, input string tag,
                      input bit cc = 0, input bit ce = 0);
    @(negedge clk);
    cur_is_read = !we;
    if (!we) begin exp_q.push_back(exp); tag_q.push_back(tag); end
    bus_cyc = 1; bus_stb = 1; bus_we = we; bus_adr = adr; bus_sel = sel; bus_dat_w = data;
    clr_capture = cc; clr_emit = ce;
    @(negedge clk);
    check({"R2 ack after request ", tag}, {31'd0, bus_ack}, 32'd1);
    bus_cyc = 0; bus_stb = 0; clr_capture = 0; clr_emit = 0;
    @(negedge clk);
    check({"R2 ack single cycle ", tag}, {31'd0, bus_ack}, 32'd0);
  endtask

  task automatic wr(input logic [7:0] adr, input logic [3:0] sel, input logic [31:0] d,
                    input string tag, input bit cc = 0, input bit ce = 0);
    xfer(1'b1, adr, sel, d, 32'h0, tag, cc, ce);
  endtask

  task automatic rd(input logic [7:0] adr, input logic [31:0] exp, input string tag);
    xfer(1'b0, adr, 4'hF, 32'h0, exp, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 ack", {31'd0, bus_ack}, 32'd0);
    check("R1 ctrl_word", ctrl_word, 32'h0);
    check("R1 pin_out", pin_out, 32'h0);
    check("R1 pin_oe", pin_oe, 32'h0);
    rd(8'h00, 32'h0, "R1 ctrl read");

    // R3 / R10 register access and lane gating
    wr(8'h08, 4'hF, 32'hA5A5_0F0F, "R3 out");
    check("R10 pin_out", pin_out, 32'hA5A5_0F0F);
    rd(8'h08, 32'hA5A5_0F0F, "R3 out read");
    wr(8'h0C, 4'b0101, 32'hFFFF_FFFF, "R3 oe lanes");
    check("R10 pin_oe", pin_oe, 32'h00FF_00FF);
    rd(8'h0C, 32'h00FF_00FF, "R3 oe read");
    wr(8'h00, 4'hF, 32'h1234_5678, "R3 ctrl");
    check("R10 ctrl_word", ctrl_word, 32'h1234_5678);
    wr(8'h00, 4'b0010, 32'h0000_AB00, "R3 ctrl lane1");
    rd(8'h00, 32'h1234_AB78, "R3 ctrl lane read");

    // R4 synchroniser latency: set pins in the same cycle as the request
    @(negedge clk);
    pin_in = 32'hDEAD_BEEF;
    cur_is_read = 1; exp_q.push_back(32'h0); tag_q.push_back("R4 pin old value");
    bus_cyc = 1; bus_stb = 1; bus_we = 0; bus_adr = 8'h04; bus_sel = 4'hF;
    @(negedge clk);
    check("R2 ack after request R4", {31'd0, bus_ack}, 32'd1);
    bus_cyc = 0; bus_stb = 0;
    rd(8'h04, 32'hDEAD_BEEF, "R4 pin new value");
    wr(8'h04, 4'hF, 32'h0, "R4 write ignored");
    rd(8'h04, 32'hDEAD_BEEF, "R4 pin after write");

    // R5 buffer words first, last, middle
    wr(8'h80, 4'h0, 32'h1111_0000, "R5 w0");
    wr(8'hFC, 4'hF, 32'h3131_3131, "R5 w31");
    wr(8'h94, 4'hF, 32'h0505_0505, "R5 w5");
    rd(8'h80, 32'h1111_0000, "R5 w0 read");
    rd(8'hFC, 32'h3131_3131, "R5 w31 read");
    rd(8'h94, 32'h0505_0505, "R5 w5 read");

    // R6 lockout while engine busy
    @(negedge clk); eng_busy = 1;
    wr(8'h80, 4'hF, 32'hBAD0_BAD0, "R6 busy write");
    rd(8'h80, 32'h0, "R6 busy read zero");
    // R7 engine port
    @(negedge clk);
    eng_ram_en = 1; eng_ram_we = 1; eng_ram_addr = 5'd3; eng_ram_wdata = 32'hC0DE_0003;
    @(negedge clk);
    eng_ram_we = 0; eng_ram_addr = 5'd0;
    @(negedge clk);
    check("R7 engine reads bus data", eng_ram_rdata, 32'h1111_0000);
    eng_ram_en = 0;
    @(negedge clk); eng_busy = 0;
    rd(8'h80, 32'h1111_0000, "R6 dropped write left word");
    rd(8'h8C, 32'hC0DE_0003, "R7 bus sees engine data");

    // R8 clear priority over same-cycle write
    wr(8'h00, 4'hF, 32'h0000_0003, "R8 write with cap clear", 1'b1, 1'b0);
    check("R8 cap cleared", ctrl_word, 32'h0000_0002);
    wr(8'h00, 4'hF, 32'h0000_00FF, "R8 write with emit clear", 1'b0, 1'b1);
    check("R8 emit cleared", ctrl_word, 32'h0000_00FD);
    @(negedge clk); clr_capture = 1;
    @(negedge clk); clr_capture = 0;
    check("R8 standalone cap clear", ctrl_word, 32'h0000_00FC);

    // R9 holes
    rd(8'h40, 32'h0, "R9 hole read");
    rd(8'h10, 32'h0, "R9 hole 0x10 read");
    wr(8'h48, 4'hF, 32'hFFFF_FFFF, "R9 hole write");
    wr(8'h18, 4'hF, 32'hFFFF_FFFF, "R9 hole write 0x18");
    rd(8'h00, 32'h0000_00FC, "R9 ctrl untouched");
    rd(8'h08, 32'hA5A5_0F0F, "R9 out untouched");
    rd(8'h0C, 32'h00FF_00FF, "R9 oe untouched");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) check("R2 reads left unanswered", exp_q.size(), 32'd0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule